// File: doc/BRIEF.md
# Core Presence Snoop Filter

This block sits beside an inclusive shared last-level cache serving four private core caches. For every line index it keeps a small presence vector with one bit per core; a set bit means that core's private caches may hold a copy. Each request names the requesting core, the line index, an operation and whether the shared cache hit. The block answers with the set of cores that must be snooped, a flag that is high when any snoop is needed, and a flag that marks a line known to be clean because several cores share it.

Because the shared cache is inclusive, a miss needs no snoop at all, and a hit only needs to reach the cores whose bits are set. Fills, ownership requests, silent drops and evictions update the vector in the same cycle the request is accepted. A request is accepted on a single-cycle valid/ready handshake. The answer is registered and appears on the next cycle. It is held until the consumer takes it.

Top module: `core_presence_dir`

## Requirements
- R1: Reset clears every presence vector to zero and drops any pending response; afterwards `req_ready` is high and `rsp_valid` is low.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is held or `rsp_ready` is high. The response appears on the following cycle and holds stable until taken with `rsp_ready`.
- R3: A request with `req_hit` low produces an all-zero snoop mask. A read (op 0) or an ownership read (op 1) that misses sets the line's vector to the requester's bit alone.
- R4: A read (op 0) that hits snoops the marked cores other than the requester, and adds the requester's bit to the vector.
- R5: An ownership read (op 1) that hits snoops the marked cores other than the requester, and leaves only the requester's bit set.
- R6: An eviction (op 2) that hits snoops every marked core, whatever `req_core` is, and clears the vector. An eviction or a drop that misses leaves the vector unchanged.
- R7: A drop (op 3) that hits snoops no core and clears only the requester's bit.
- R8: `rsp_snoop` is high exactly when the snoop mask has at least one bit set.
- R9: `rsp_shared` is high for a hitting op 0, 1 or 2 whose vector had two or more bits set before the update. Otherwise it is low.
- R10: For ops 0, 1 and 3, the snoop mask never contains the requesting core's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_core | input | CW (2) | Requesting core number |
| req_line | input | LW (4) | Line index into the presence array |
| req_op | input | 2 | 0 read, 1 ownership read, 2 evict, 3 drop |
| req_hit | input | 1 | Shared cache hit for this line |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_mask | output | NCORES (4) | Cores to snoop, bit i for core i |
| rsp_snoop | output | 1 | At least one snoop is needed |
| rsp_shared | output | 1 | Line held by several cores, so no copy can be dirty |

## Verification
The following properties are checked on every cycle:
- a missing request always yields an empty mask;
- the requester never appears in its own mask for ops 0, 1 and 3;
- a drop never snoops;
- a shared-line answer always names some core;
- a stalled response keeps its value;
- the snoop flag tracks the mask.

Properties that depend on the history of a line can only be shown by the bench's scenarios, whose scoreboard keeps its own presence table. These include:
- a vector built up by reads from several cores;
- an ownership read collapsing the vector to a single bit;
- an eviction snooping every holder;
- a stale vector being replaced on a miss;
- a mid-run reset wiping the table.

// File: rtl/core_presence_dir.sv
module core_presence_dir #(
  parameter int NCORES = 4,
  parameter int NLINES = 16,
  localparam int CW = $clog2(NCORES),
  localparam int LW = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CW-1:0]     req_core,
  input  logic [LW-1:0]     req_line,
  input  logic [1:0]        req_op,
  input  logic              req_hit,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [NCORES-1:0] rsp_mask,
  output logic              rsp_snoop,
  output logic              rsp_shared
);
  localparam logic [1:0] OP_RD = 2'd0, OP_OWN = 2'd1, OP_EVICT = 2'd2, OP_DROP = 2'd3;

  logic [NCORES-1:0] pres [NLINES];
  logic [NCORES-1:0] cur, self_bit, nxt_vec, nxt_mask;
  logic              nxt_shared, multi, accept;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign cur       = pres[req_line];
  assign self_bit  = NCORES'(1) << req_core;
  assign multi     = $countones(cur) > 1;

  always_comb begin
    nxt_vec    = cur;
    nxt_mask   = '0;
    nxt_shared = 1'b0;
    if (!req_hit) begin
      if (req_op == OP_RD || req_op == OP_OWN) nxt_vec = self_bit;
    end else begin
      case (req_op)
        OP_RD: begin
          nxt_mask   = cur & ~self_bit;
          nxt_shared = multi;
          nxt_vec    = cur | self_bit;
        end
        OP_OWN: begin
          nxt_mask   = cur & ~self_bit;
          nxt_shared = multi;
          nxt_vec    = self_bit;
        end
        OP_EVICT: begin
          nxt_mask   = cur;
          nxt_shared = multi;
          nxt_vec    = '0;
        end
        default: nxt_vec = cur & ~self_bit;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) pres[i] <= '0;
      rsp_valid  <= 1'b0;
      rsp_mask   <= '0;
      rsp_snoop  <= 1'b0;
      rsp_shared <= 1'b0;
    end else if (accept) begin
      pres[req_line] <= nxt_vec;
      rsp_valid      <= 1'b1;
      rsp_mask       <= nxt_mask;
      rsp_snoop      <= |nxt_mask;
      rsp_shared     <= nxt_shared;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/core_presence_dir_chk.sv
module core_presence_dir_chk #(
  parameter int NCORES = 4,
  parameter int NLINES = 16,
  localparam int CW = $clog2(NCORES),
  localparam int LW = $clog2(NLINES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [CW-1:0]     req_core,
  input logic [LW-1:0]     req_line,
  input logic [1:0]        req_op,
  input logic              req_hit,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [NCORES-1:0] rsp_mask,
  input logic              rsp_snoop,
  input logic              rsp_shared
);
  logic acc;
  assign acc = req_valid && req_ready;

  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !rsp_valid);

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_mask) && $stable(rsp_shared));

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  assert_miss_no_snoop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_hit) |=> rsp_mask == '0);

  assert_drop_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'd3) |=> rsp_mask == '0);

  assert_flag_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_snoop == (rsp_mask != '0));

  assert_shared_names_core_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_shared) |-> $countones(rsp_mask) >= 1);

  assert_not_self_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op != 2'd2) |=> !rsp_mask[$past(req_core)]);
endmodule

bind core_presence_dir core_presence_dir_chk #(.NCORES(NCORES), .NLINES(NLINES)) u_chk (.*);

// File: tb/sim_core_presence_dir.sv
`timescale 1ns/1ps
module sim_core_presence_dir;
  logic       clk = 0, rst_n = 0;
  logic       req_valid = 0, req_hit = 0, rsp_ready = 1;
  logic [1:0] req_core = 0, req_op = 0;
  logic [3:0] req_line = 0;
  logic       req_ready, rsp_valid, rsp_snoop, rsp_shared;
  logic [3:0] rsp_mask;

  core_presence_dir u0 (.*);

  always #2.5 clk = ~clk;

  int         checks = 0, fails = 0;
  logic [3:0] mdl [16];
  logic [5:0] exp_q [$];
  string      tag_q [$];
  logic       bp_en = 0;
  logic [7:0] lfsr = 8'h5a;

  task automatic chk(input bit ok, input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rsp_ready <= bp_en ? lfsr[0] : 1'b1;
    #1;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected response", {rsp_mask, rsp_snoop, rsp_shared}, '0);
      else begin
        logic [5:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({rsp_mask, rsp_snoop, rsp_shared} == e, t, {rsp_mask, rsp_snoop, rsp_shared}, e);
      end
    end
  end

  task automatic send(input int c, input int l, input int op, input bit hit, input string tag);
    logic [3:0] cur, self, m;
    bit sh;
    cur = mdl[l]; self = 4'(1) << c; m = '0; sh = 0;
    if (!hit) begin
      if (op < 2) mdl[l] = self;
    end else case (op)
      0: begin m = cur & ~self; sh = $countones(cur) > 1; mdl[l] = cur | self; end
      1: begin m = cur & ~self; sh = $countones(cur) > 1; mdl[l] = self; end
      2: begin m = cur; sh = $countones(cur) > 1; mdl[l] = '0; end
      default: mdl[l] = cur & ~self;
    endcase
    exp_q.push_back({m, |m, sh});
    tag_q.push_back(tag);
    @(negedge clk); #2;
    req_valid = 1; req_core = 2'(c); req_line = 4'(l); req_op = 2'(op); req_hit = hit;
    while (!req_ready) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<100000", wd);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    do_reset();
    @(negedge clk); #2;
    chk(!rsp_valid && req_ready, "R1 reset idle", {4'b0, rsp_valid, req_ready}, 6'b000001);

    send(0, 3, 0, 0, "R3 read miss fill");
    send(1, 3, 0, 1, "R4 read hit one holder");
    send(2, 3, 0, 1, "R9 read hit shared two holders");
    send(3, 3, 1, 1, "R5 ownership snoops three");
    send(0, 3, 0, 1, "R4 read after ownership");
    send(2, 3, 2, 1, "R6 evict snoops all");
    send(1, 3, 0, 1, "R6 vector cleared after evict");
    send(1, 3, 3, 1, "R7 drop silent");
    send(1, 3, 0, 1, "R7 drop cleared own bit");
    send(2, 5, 0, 0, "R3 miss");
    send(3, 5, 0, 1, "R4 second reader");
    send(0, 5, 1, 0, "R3 ownership miss no snoop");
    send(1, 5, 0, 1, "R3 stale vector replaced");
    send(2, 5, 2, 0, "R6 evict miss no effect");
    send(2, 5, 3, 0, "R6 drop miss no effect");
    send(3, 5, 1, 1, "R10 requester excluded");
    send(3, 5, 0, 1, "R10 sole holder rereads");
    drain();

    bp_en = 1;
    for (int i = 0; i < 300; i++) begin
      send(int'(lfsr[1:0]), int'(lfsr[6:4]), int'(lfsr[3:2]), lfsr[7] | lfsr[5], "R2 backpressure mix R8");
    end
    drain();
    bp_en = 0;

    send(0, 9, 0, 0, "R4 prep");
    send(1, 9, 0, 1, "R4 prep2");
    drain();
    do_reset();
    @(negedge clk); #2;
    chk(!rsp_valid && req_ready, "R1 idle after reset", {4'b0, rsp_valid, req_ready}, 6'b000001);
    send(2, 9, 0, 1, "R1 vector cleared by reset");
    drain();
    chk(exp_q.size() == 0, "R2 all responses seen", 6'(exp_q.size()), '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule